// File: doc/BRIEF.md
# Serial EEPROM Word Write Sequencer

This block stores one 16-bit word into a serial EEPROM over a four-wire SPI link in mode 0. A requester pulses `start` with a word offset and a data word. The block first compares the offset against the device size given on `word_count`. An out-of-range request is refused with an error pulse, and the SPI pins stay quiet.

An accepted request runs through a fixed sequence of chip-select frames. The block polls the device status register until the device reports that it is not busy, giving up after a bounded number of tries. It then sends a stand-alone write-enable opcode. Next comes the write frame: an opcode, then the byte address (the word offset doubled), then the data word with its bytes exchanged, so the low byte leaves first. After chip select goes high, the block counts a programmable settle time and pulses `done`. On parts with 8 address bits, the ninth address bit is carried in the opcode.

The SPI clock runs at the system clock divided by 2×`CLK_DIV`. The opcode values and the poll limit are parameters.

Top module: `eeprom_word_writer`

## Requirements
- R1: A `start` in idle whose `word_off` is equal to or greater than `word_count` raises `err` for exactly the next cycle. Chip select is never asserted for that request.
- R2: An accepted request first sends one or more 16-clock status frames, each beginning with the opcode 0x05. The second byte is read from `spi_miso`. The block sends a further status frame whenever bit 0 of that byte (busy) is 1.
- R3: If `POLL_MAX` (default 8) status frames in a row all report busy, the block raises `err` after the last of them and sends no further frames.
- R4: Once the device reports not busy, the block sends a frame of exactly 8 clocks carrying 0x06. Chip select is high immediately before and after this frame.
- R5: The write frame begins with the opcode 0x02. When `cfg_addr8` is 1 and the offset is 128 or more, the opcode becomes 0x0A (0x08 ORed in).
- R6: After the opcode, the write frame carries the byte address, equal to the offset times two, MSB first. It is 8 bits wide when `cfg_addr8`=1 (the low 8 bits of the address) and 16 bits wide otherwise.
- R7: The write frame ends with 16 data bits, MSB first: `wr_data[7:0]` followed by `wr_data[15:8]`. The frame has 32 clocks with 8-bit addressing and 40 clocks with 16-bit addressing.
- R8: `done` pulses for one cycle exactly `settle_cycles`+1 clock cycles after chip select rises at the end of the write frame. `done` and `err` are one-cycle pulses, never both high, and `busy` is low while either is high.
- R9: Out of reset, and whenever chip select is high, `spi_sck` is low. After reset `busy`, `done` and `err` are low.
- R10: A `start` that arrives while `busy` is high is ignored. The frames sent carry the offset and data that were latched when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| word_off | input | 16 | Word offset to write |
| wr_data | input | 16 | Data word to write |
| word_count | input | 16 | Device size in words |
| cfg_addr8 | input | 1 | 1: 8-bit addressing, 0: 16-bit addressing |
| settle_cycles | input | 16 | Wait after the write frame, in clock cycles |
| spi_miso | input | 1 | Serial data from the device |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: write finished |
| err | output | 1 | One-cycle pulse: request refused or device never ready |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the device |

## Verification
A refused request produces `err` in the first cycle after the accepting edge. The bench samples at the falling edge that follows its `start` pulse and requires the pulse there, and it also counts chip-select falls to confirm that nothing was sent. A completion arrives `settle_cycles`+1 cycles after the final chip-select rise. The bench timestamps that rise with a cycle counter, takes the cycle in which `done` is seen, and requires the exact difference rather than a window. It then reads the serial frames as a device model would: bits are taken at each rising SCK edge, and `spi_miso` changes only after the design has sampled it. Each frame's clock count and content are compared once its chip select rises.

// File: rtl/eeprom_word_writer.sv
module eeprom_word_writer #(
  parameter int        CLK_DIV  = 2,
  parameter int        POLL_MAX = 8,
  parameter logic [7:0] OP_WREN = 8'h06,
  parameter logic [7:0] OP_WRITE = 8'h02,
  parameter logic [7:0] OP_RDSR = 8'h05,
  parameter logic [7:0] OP_A8   = 8'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] word_off,
  input  logic [15:0] wr_data,
  input  logic [15:0] word_count,
  input  logic        cfg_addr8,
  input  logic [15:0] settle_cycles,
  input  logic        spi_miso,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TRY_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_MAX - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_SHIFT, ST_SETTLE} state_t;
  typedef enum logic [1:0] {FR_POLL, FR_WREN, FR_WRITE} frame_t;

  state_t state;
  frame_t kind;
  logic [39:0] sh;
  logic [5:0]  nbits;
  logic [DIV_W-1:0] div;
  logic [TRY_W-1:0] tries;
  logic [7:0]  rx;
  logic [15:0] wait_q, settle_q, off_q, data_q;
  logic        addr8_q;

  wire [15:0] byte_addr = {off_q[14:0], 1'b0};
  wire [7:0]  wr_op     = OP_WRITE | ((addr8_q && off_q >= 16'd128) ? OP_A8 : 8'h00);
  wire [15:0] data_sw   = {data_q[7:0], data_q[15:8]};
  wire [39:0] write_img = addr8_q ? {wr_op, byte_addr[7:0], data_sw, 8'h00}
                                  : {wr_op, byte_addr, data_sw};
  wire [5:0]  write_len = addr8_q ? 6'd32 : 6'd40;

  assign busy     = (state != ST_IDLE);
  assign spi_cs_n = (state != ST_SHIFT);
  assign spi_mosi = (state == ST_SHIFT) ? sh[39] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= FR_POLL;
      sh       <= '0;
      nbits    <= '0;
      div      <= '0;
      tries    <= '0;
      rx       <= '0;
      wait_q   <= '0;
      settle_q <= '0;
      off_q    <= '0;
      data_q   <= '0;
      addr8_q  <= 1'b0;
      spi_sck  <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (word_off >= word_count) begin
              err <= 1'b1;
            end else begin
              off_q    <= word_off;
              data_q   <= wr_data;
              addr8_q  <= cfg_addr8;
              settle_q <= settle_cycles;
              kind     <= FR_POLL;
              sh       <= {OP_RDSR, 32'h0};
              nbits    <= 6'd16;
              tries    <= '0;
              div      <= '0;
              state    <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (div == DIV_LAST) begin
            div   <= '0;
            state <= ST_SHIFT;
          end else begin
            div <= div + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (div != DIV_LAST) begin
            div <= div + 1'b1;
          end else begin
            div <= '0;
            if (!spi_sck) begin
              spi_sck <= 1'b1;
              rx      <= {rx[6:0], spi_miso};
            end else begin
              spi_sck <= 1'b0;
              sh      <= sh << 1;
              if (nbits != 6'd1) begin
                nbits <= nbits - 1'b1;
              end else begin
                case (kind)
                  FR_POLL: begin
                    if (!rx[0]) begin
                      kind  <= FR_WREN;
                      sh    <= {OP_WREN, 32'h0};
                      nbits <= 6'd8;
                      state <= ST_GAP;
                    end else if (tries == TRY_LAST) begin
                      err   <= 1'b1;
                      state <= ST_IDLE;
                    end else begin
                      tries <= tries + 1'b1;
                      sh    <= {OP_RDSR, 32'h0};
                      nbits <= 6'd16;
                      state <= ST_GAP;
                    end
                  end
                  FR_WREN: begin
                    kind  <= FR_WRITE;
                    sh    <= write_img;
                    nbits <= write_len;
                    state <= ST_GAP;
                  end
                  default: begin
                    wait_q <= '0;
                    state  <= ST_SETTLE;
                  end
                endcase
              end
            end
          end
        end
        default: begin
          if (wait_q == settle_q) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            wait_q <= wait_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/eeprom_word_writer_chk.sv
module eeprom_word_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [15:0] word_off,
  input logic [15:0] word_count,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        spi_cs_n,
  input logic        spi_sck
);

  assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (word_off >= word_count)) |=> (err && !busy));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && !spi_sck));

  assert_sck_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));

endmodule

bind eeprom_word_writer eeprom_word_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .word_off(word_off),
  .word_count(word_count), .busy(busy), .done(done), .err(err),
  .spi_cs_n(spi_cs_n), .spi_sck(spi_sck)
);

// File: tb/eeprom_word_writer_bench.sv
`timescale 1ns/1ps
module eeprom_word_writer_bench;
  localparam int CLK_DIV = 2;
  localparam int POLL_MAX = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cfg_addr8 = 1'b0;
  logic [15:0] word_off = '0, wr_data = '0, word_count = '0, settle_cycles = '0;
  logic spi_miso, busy, done, err, spi_cs_n, spi_sck, spi_mosi;

  always #2.5 clk = ~clk;

  eeprom_word_writer #(.CLK_DIV(CLK_DIV), .POLL_MAX(POLL_MAX)) u_eeprom_word_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .word_off(word_off), .wr_data(wr_data),
    .word_count(word_count), .cfg_addr8(cfg_addr8), .settle_cycles(settle_cycles),
    .spi_miso(spi_miso), .busy(busy), .done(done), .err(err),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi));

  int checks = 0, fails = 0, cyc = 0, cs_rise_cyc = 0, cs_falls = 0;
  int bitk = 0, fr_n = 0, busy_polls = 0, sck_viol = 0;
  logic [63:0] cur_val = '0;
  int fr_bits[16];
  logic [63:0] fr_val[16];
  bit finished = 0;

  always @(posedge clk) cyc++;
  always @(negedge spi_cs_n) begin bitk = 0; cur_val = '0; cs_falls++; end
  always @(posedge spi_sck) begin cur_val = {cur_val[62:0], spi_mosi}; bitk++; end
  always @(posedge spi_cs_n) begin
    cs_rise_cyc = cyc;
    if (fr_n < 16) begin fr_bits[fr_n] = bitk; fr_val[fr_n] = cur_val; end
    fr_n++;
  end
  always @(negedge clk) if (rst_n && spi_cs_n && spi_sck) sck_viol++;

  wire [7:0] status = (fr_n < busy_polls) ? 8'h83 : 8'h82;
  assign spi_miso = (bitk >= 8 && bitk < 16) ? status[3'(15 - bitk)] : 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] off, input logic [15:0] data,
                        input logic [15:0] cnt, input bit a8, input logic [15:0] st,
                        input int bp, input bit mid);
    int n;
    bit got_done, got_err;
    int done_cyc, wi, abits;
    logic [7:0] e_op;
    logic [15:0] e_addr, e_data, ba;
    @(negedge clk);
    word_off = off; wr_data = data; word_count = cnt; cfg_addr8 = a8;
    settle_cycles = st; busy_polls = bp; fr_n = 0; cs_falls = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (off >= cnt) begin
      chk(err && !done, "R1", "refusal pulse", {err, done}, 2'b10);
      repeat (20) @(negedge clk);
      chk(cs_falls == 0, "R1", "chip select falls", cs_falls, 0);
      return;
    end
    n = 0;
    while (!done && !err && n < 30000) begin
      if (mid && n == 40) begin start = 1'b1; word_off = ~off; wr_data = ~data; end
      if (mid && n == 41) begin start = 1'b0; word_off = off; wr_data = data; end
      @(negedge clk);
      n++;
    end
    done_cyc = cyc; got_done = done; got_err = err;
    @(negedge clk);
    chk(!done && !err, "R8", "pulse width", {done, err}, 2'b00);
    for (int i = 0; i < ((bp >= POLL_MAX) ? POLL_MAX : bp + 1); i++) begin
      chk(fr_bits[i] == 16 && fr_val[i][15:8] == 8'h05, "R2", "status frame",
          {fr_bits[i][7:0], fr_val[i][15:8]}, {8'd16, 8'h05});
    end
    if (bp >= POLL_MAX) begin
      chk(got_err && !got_done, "R3", "timeout pulse", {got_err, got_done}, 2'b10);
      chk(fr_n == POLL_MAX, "R3", "frame count", fr_n, POLL_MAX);
      return;
    end
    chk(got_done && !got_err, "R8", "done pulse", {got_done, got_err}, 2'b10);
    chk(fr_n == bp + 3, "R2", "frame count", fr_n, bp + 3);
    chk(fr_bits[bp + 1] == 8 && fr_val[bp + 1][7:0] == 8'h06, "R4", "write enable frame",
        {fr_bits[bp + 1][7:0], fr_val[bp + 1][7:0]}, {8'd8, 8'h06});
    wi = bp + 2;
    abits = a8 ? 8 : 16;
    ba = {off[14:0], 1'b0};
    e_op = 8'h02 | ((a8 && off >= 16'd128) ? 8'h08 : 8'h00);
    e_addr = a8 ? {8'h00, ba[7:0]} : ba;
    e_data = {data[7:0], data[15:8]};
    chk(fr_bits[wi] == 24 + abits, "R7", "write frame clocks", fr_bits[wi], 24 + abits);
    chk(fr_val[wi][23 + abits -: 8] == e_op, "R5", "write opcode",
        fr_val[wi][23 + abits -: 8], e_op);
    chk((a8 ? {8'h00, fr_val[wi][23:16]} : fr_val[wi][31:16]) == e_addr, "R6", "byte address",
        a8 ? {8'h00, fr_val[wi][23:16]} : fr_val[wi][31:16], e_addr);
    chk(fr_val[wi][15:0] == e_data, mid ? "R10" : "R7", "data bits", fr_val[wi][15:0], e_data);
    chk(done_cyc - cs_rise_cyc == int'(st) + 1, "R8", "settle cycles",
        done_cyc - cs_rise_cyc, int'(st) + 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(spi_cs_n && !spi_sck && !busy && !done && !err, "R9", "reset state",
        {spi_cs_n, spi_sck, busy, done, err}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_op(16'd64, 16'h1234, 16'd64, 1'b1, 16'd3, 0, 1'b0);
    run_op(16'd300, 16'h1234, 16'd64, 1'b0, 16'd3, 0, 1'b0);
    run_op(16'd63, 16'hA55A, 16'd64, 1'b1, 16'd0, 0, 1'b0);
    run_op(16'd127, 16'hBEEF, 16'd256, 1'b1, 16'd5, 1, 1'b0);
    run_op(16'd128, 16'hC0DE, 16'd256, 1'b1, 16'd2, 0, 1'b0);
    run_op(16'd255, 16'h00FF, 16'd256, 1'b1, 16'd1, 3, 1'b0);
    run_op(16'h7FFF, 16'hFF00, 16'hFFFF, 1'b0, 16'd7, 0, 1'b0);
    run_op(16'd200, 16'h4321, 16'd1024, 1'b0, 16'd4, POLL_MAX - 1, 1'b0);
    run_op(16'd17, 16'h5555, 16'd1024, 1'b0, 16'd4, POLL_MAX, 1'b0);
    run_op(16'd90, 16'h9A3C, 16'd1024, 1'b0, 16'd9, 0, 1'b1);
    for (int k = 0; k < 24; k++) begin
      bit a8 = 1'($urandom % 2);
      logic [15:0] cnt = a8 ? 16'd256 : 16'(1 + $urandom % 32767);
      logic [15:0] off = 16'($urandom % (int'(cnt) + 4));
      run_op(off, 16'($urandom), cnt, a8, 16'($urandom % 64),
             int'($urandom % (POLL_MAX + 2)), 1'($urandom % 2));
    end
    chk(sck_viol == 0, "R9", "clock high while deselected", sck_viol, 0);
    summary();
  end
endmodule